// File: doc/BRIEF.md
# Frame Sync Lock Qualifier

This block turns the raw match pulses of a sync-pattern correlator into a frame-lock status for a serial PCM stream. A bit-position counter runs on every enabled bit and is compared against a programmed frame length. Once the machine has left its search state, a match counts only when it falls on the bit the counter predicts as the frame boundary. A match anywhere else is ignored.

Four states are used. In search, any match starts a new frame. Verify needs a run of boundary hits before lock is declared. In lock, a single boundary miss moves the machine to check. From check, either a run of boundary misses or a timeout measured in frames returns it to search. A boundary hit in check restores lock at once.

The hit threshold, the miss threshold and the check timeout are inputs. The intended settings are 3, 3 and 8. While the machine is in lock or check, it emits a one-cycle pulse at every expected frame boundary.

Top module: `fsync_lock_fsm`

## Requirements
- R1: While reset is applied, and after it, the outputs are `lock_state`=0, `frame_start`=0 and `bit_pos`=0.
- R2: `lock_state` uses the encoding search=0, verify=1, lock=2, check=3. In search, an enabled bit with `sync_hit` high restarts the counter so that `bit_pos` reads 0 after that bit. The machine then enters verify with one hit counted, or enters lock directly when `hit_need` is 1 or less.
- R3: Outside search, the expected boundary is the enabled bit on which `bit_pos` equals `frame_len`-1. A `sync_hit` on any other bit has no effect on the state.
- R4: In verify, each boundary hit adds one to the hit count. When the count reaches `hit_need` (the first search hit included), the state becomes lock.
- R5: In verify, a boundary bit without `sync_hit` returns the state to search.
- R6: In lock, a boundary miss moves the state to check with one miss counted. When `miss_need` is 1 or less, it moves to search instead.
- R7: In check, a boundary hit returns the state to lock and clears the miss count.
- R8: In check, when the count of consecutive boundary misses reaches `miss_need`, the state becomes search.
- R9: In check, the state also becomes search at the boundary where the number of boundaries evaluated in check reaches `check_frames`, whatever the miss count.
- R10: `frame_start` is high for one cycle after each boundary bit processed while the state was lock or check, and is low otherwise.
- R11: A cycle with `bit_en` low changes neither `lock_state` nor `bit_pos`.
- R12: `bit_pos` advances by one on each enabled bit and wraps from `frame_len`-1 to 0. All outputs are registered and reflect an enabled bit one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies one serial bit per cycle |
| sync_hit | input | 1 | Raw correlator match on this bit |
| frame_len | input | LEN_W | Frame length in bits (at least 2) |
| hit_need | input | CNT_W | Boundary hits required to lock |
| miss_need | input | CNT_W | Consecutive misses that drop lock |
| check_frames | input | CNT_W | Check-state timeout in frames |
| lock_state | output | 2 | Current state: 0 search, 1 verify, 2 lock, 3 check |
| frame_start | output | 1 | Pulse at each expected boundary in lock or check |
| bit_pos | output | LEN_W | Bit position within the frame |

## Verification
The hardest case to reach is the check timeout that fires before the miss threshold. With the intended settings, the miss threshold always fires first, so the timeout path is never taken. The bench therefore reprograms the miss threshold to 5 and the timeout to 1 after a reset, acquires lock, and feeds two boundary misses. Off-boundary matches are placed deliberately in verify and in lock, using a reference model of the bit position, to show that they are ignored.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [1:0] {
    FS_SEARCH = 2'd0,
    FS_VERIFY = 2'd1,
    FS_LOCK   = 2'd2,
    FS_CHECK  = 2'd3
  } fs_state_e;
endpackage

// File: rtl/fsl_bit_counter.sv
module fsl_bit_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             restart,
  input  logic [LEN_W-1:0] frame_len,
  output logic [LEN_W-1:0] pos,
  output logic             at_bnd
);
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] last_pos;

  assign last_pos = frame_len - LEN_W'(1);
  assign at_bnd   = (pos_q == last_pos);
  assign pos      = pos_q;

  always_comb begin
    pos_d = pos_q;
    if (bit_en) begin
      if (restart || at_bnd) pos_d = '0;
      else                   pos_d = pos_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assert_wrap_at_boundary_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && at_bnd) |=> (pos_q == '0));
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en) |=> $stable(pos_q));
endmodule

// File: rtl/fsl_check_timer.sv
module fsl_check_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             at_bnd,
  input  logic             in_check,
  input  logic [CNT_W-1:0] check_frames,
  output logic             expire
);
  logic [CNT_W-1:0] chk_q, chk_d;
  logic [CNT_W:0]   chk_next;

  assign chk_next = {1'b0, chk_q} + (CNT_W+1)'(1);
  assign expire   = in_check && bit_en && at_bnd &&
                    (chk_next >= {1'b0, check_frames});

  always_comb begin
    chk_d = chk_q;
    if (!in_check)              chk_d = '0;
    else if (bit_en && at_bnd)  chk_d = chk_next[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_q <= '0;
    else        chk_q <= chk_d;
  end

  assert_timer_idle_outside_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_check) |=> (chk_q == '0));
endmodule

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
  import fsl_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sync_hit,
  input  logic             at_bnd,
  input  logic             expire,
  input  logic [CNT_W-1:0] hit_need,
  input  logic [CNT_W-1:0] miss_need,
  output fs_state_e        state,
  output logic             restart,
  output logic             frame_start
);
  fs_state_e        st_q, st_d;
  logic [CNT_W-1:0] hits_q, hits_d;
  logic [CNT_W-1:0] miss_q, miss_d;
  logic             fs_q, fs_d;

  assign state       = st_q;
  assign frame_start = fs_q;

  always_comb begin
    st_d    = st_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    restart = 1'b0;
    fs_d    = bit_en && at_bnd && (st_q == FS_LOCK || st_q == FS_CHECK);
    if (bit_en) begin
      unique case (st_q)
        FS_SEARCH: begin
          if (sync_hit) begin
            restart = 1'b1;
            hits_d  = CNT_W'(1);
            miss_d  = '0;
            st_d    = (hit_need <= CNT_W'(1)) ? FS_LOCK : FS_VERIFY;
          end
        end
        FS_VERIFY: begin
          if (at_bnd) begin
            if (sync_hit) begin
              hits_d = hits_q + CNT_W'(1);
              if (hits_d >= hit_need) begin
                st_d   = FS_LOCK;
                miss_d = '0;
              end
            end else begin
              st_d = FS_SEARCH;
            end
          end
        end
        FS_LOCK: begin
          if (at_bnd) begin
            if (sync_hit) begin
              miss_d = '0;
            end else begin
              miss_d = CNT_W'(1);
              st_d   = (miss_need <= CNT_W'(1)) ? FS_SEARCH : FS_CHECK;
            end
          end
        end
        FS_CHECK: begin
          if (at_bnd) begin
            if (sync_hit) begin
              miss_d = '0;
              st_d   = FS_LOCK;
            end else begin
              miss_d = miss_q + CNT_W'(1);
              if (miss_d >= miss_need || expire) st_d = FS_SEARCH;
            end
          end
        end
        default: st_d = FS_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_SEARCH;
      hits_q <= '0;
      miss_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      hits_q <= hits_d;
      miss_q <= miss_d;
      fs_q   <= fs_d;
    end
  end

  assert_search_hit_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_SEARCH && bit_en && sync_hit) |=> (st_q == FS_VERIFY || st_q == FS_LOCK));
  assert_offbnd_ignored_in_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_LOCK && bit_en && !at_bnd) |=> (st_q == FS_LOCK));
  assert_verify_miss_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_VERIFY && bit_en && at_bnd && !sync_hit) |=> (st_q == FS_SEARCH));
  assert_lock_miss_leaves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_LOCK && bit_en && at_bnd && !sync_hit) |=> (st_q == FS_CHECK || st_q == FS_SEARCH));
  assert_check_hit_relocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_CHECK && bit_en && at_bnd && sync_hit) |=> (st_q == FS_LOCK));
  assert_timeout_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_CHECK && !sync_hit && expire) |=> (st_q == FS_SEARCH));
  assert_pulse_only_when_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(st_q) == FS_LOCK || $past(st_q) == FS_CHECK));
  assert_state_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en) |=> $stable(st_q));
endmodule

// File: rtl/fsync_lock_fsm.sv
module fsync_lock_fsm
  import fsl_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             sync_hit,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [CNT_W-1:0] hit_need,
  input  logic [CNT_W-1:0] miss_need,
  input  logic [CNT_W-1:0] check_frames,
  output logic [1:0]       lock_state,
  output logic             frame_start,
  output logic [LEN_W-1:0] bit_pos
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  fs_state_e              state;
  logic                   restart;
  logic                   at_bnd;
  logic                   expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  fsl_bit_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bit_en    (bit_en),
    .restart   (restart),
    .frame_len (frame_len),
    .pos       (bit_pos),
    .at_bnd    (at_bnd)
  );

  fsl_check_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .bit_en       (bit_en),
    .at_bnd       (at_bnd),
    .in_check     (state == FS_CHECK),
    .check_frames (check_frames),
    .expire       (expire)
  );

  fsl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .bit_en      (bit_en),
    .sync_hit    (sync_hit),
    .at_bnd      (at_bnd),
    .expire      (expire),
    .hit_need    (hit_need),
    .miss_need   (miss_need),
    .state       (state),
    .restart     (restart),
    .frame_start (frame_start)
  );

  assign lock_state = state;
endmodule

// File: tb/fsync_lock_fsm_bench.sv
module fsync_lock_fsm_bench;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_en = 1'b0;
  logic             sync_hit = 1'b0;
  logic [LEN_W-1:0] frame_len = 16'd8;
  logic [CNT_W-1:0] hit_need = 4'd3;
  logic [CNT_W-1:0] miss_need = 4'd3;
  logic [CNT_W-1:0] check_frames = 4'd8;
  logic [1:0]       lock_state;
  logic             frame_start;
  logic [LEN_W-1:0] bit_pos;

  always #10 clk = ~clk;

  fsync_lock_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsync_lock_fsm (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_hit(sync_hit),
    .frame_len(frame_len), .hit_need(hit_need), .miss_need(miss_need),
    .check_frames(check_frames), .lock_state(lock_state),
    .frame_start(frame_start), .bit_pos(bit_pos)
  );

  typedef struct {
    int    st;
    bit    fs;
    int    pos;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_st, m_pos, m_hits, m_miss, m_chk;

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_hits = 0; m_miss = 0; m_chk = 0;
  endtask

  task automatic step(input bit en, input bit hit, input string tag);
    exp_t e;
    bit bnd, fs;
    @(negedge clk);
    bit_en   = en;
    sync_hit = hit;
    fs = 1'b0;
    if (en) begin
      bnd = (m_pos == int'(frame_len) - 1);
      fs  = bnd && (m_st == 2 || m_st == 3);
      if (m_st == 0) begin
        if (hit) begin
          m_pos = 0; m_hits = 1; m_miss = 0;
          m_st = (int'(hit_need) <= 1) ? 2 : 1;
        end else begin
          m_pos = bnd ? 0 : m_pos + 1;
        end
      end else begin
        m_pos = bnd ? 0 : m_pos + 1;
        if (bnd) begin
          case (m_st)
            1: if (hit) begin
                 m_hits++;
                 if (m_hits >= int'(hit_need)) begin m_st = 2; m_miss = 0; end
               end else m_st = 0;
            2: if (hit) m_miss = 0;
               else begin
                 m_miss = 1; m_chk = 0;
                 m_st = (int'(miss_need) <= 1) ? 0 : 3;
               end
            default: if (hit) begin m_st = 2; m_miss = 0; end
               else begin
                 m_miss++; m_chk++;
                 if (m_miss >= int'(miss_need) || m_chk >= int'(check_frames)) m_st = 0;
               end
          endcase
        end
      end
    end
    e.st = m_st; e.fs = fs; e.pos = m_pos; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic bits(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
  endtask

  task automatic to_boundary(input bit hit, input string tag);
    while (m_pos != int'(frame_len) - 1) step(1'b1, 1'b0, tag);
    step(1'b1, hit, tag);
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0; sync_hit = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; sync_hit = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    checks++;
    if (lock_state !== 2'd0 || frame_start !== 1'b0 || bit_pos !== '0) begin
      errors++;
      $display("FAIL R1 reset: state=%0d fs=%0b pos=%0d expected 0 0 0",
               lock_state, frame_start, bit_pos);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (lock_state !== 2'd0 || frame_start !== 1'b0 || bit_pos !== '0) begin
      errors++;
      $display("FAIL R1 after reset: state=%0d fs=%0b pos=%0d expected 0 0 0",
               lock_state, frame_start, bit_pos);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (int'(lock_state) != e.st || frame_start != e.fs || int'(bit_pos) != e.pos) begin
          errors++;
          $display("FAIL %s: state=%0d fs=%0b pos=%0d expected state=%0d fs=%0b pos=%0d",
                   e.tag, lock_state, frame_start, bit_pos, e.st, e.fs, e.pos);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    model_reset();
    do_reset();
    // Intended settings 3/3/8, frame of 8 bits
    bits(3, "R12");
    step(1'b1, 1'b1, "R2");
    step(1'b1, 1'b1, "R3");
    step(1'b0, 1'b0, "R11");
    step(1'b0, 1'b1, "R11");
    step(1'b0, 1'b0, "R11");
    to_boundary(1'b1, "R4");
    to_boundary(1'b1, "R4");
    to_boundary(1'b1, "R10");
    step(1'b1, 1'b1, "R3");
    to_boundary(1'b1, "R10");
    to_boundary(1'b0, "R6");
    to_boundary(1'b1, "R7");
    to_boundary(1'b0, "R8");
    to_boundary(1'b0, "R8");
    to_boundary(1'b0, "R8");
    bits(4, "R10");
    drain();

    // Miss while verifying
    do_reset();
    step(1'b1, 1'b1, "R2");
    to_boundary(1'b1, "R4");
    to_boundary(1'b0, "R5");
    bits(3, "R12");
    drain();

    // Timeout shorter than the miss threshold
    miss_need = 4'd5; check_frames = 4'd1;
    do_reset();
    step(1'b1, 1'b1, "R2");
    to_boundary(1'b1, "R4");
    to_boundary(1'b1, "R4");
    to_boundary(1'b0, "R6");
    to_boundary(1'b0, "R9");
    bits(2, "R9");
    drain();

    // Single-hit lock and single-miss drop
    hit_need = 4'd1; miss_need = 4'd1; check_frames = 4'd8; frame_len = 16'd5;
    do_reset();
    step(1'b1, 1'b1, "R2");
    to_boundary(1'b1, "R10");
    to_boundary(1'b0, "R6");
    bits(2, "R12");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule